// File: doc/BRIEF.md
# Staged Multichannel Reset Sequencer

This block brings a four-channel hard Ethernet interface out of reset in a fixed order. One channel is the primary and the others, chosen by a mask, are secondaries. All of them take their lane clock from one shared PLL. While the system reset is active, or after a restart request, the sequencer holds every per-channel control/status reset and the reconfiguration reset asserted. The channel resets are active low and the reconfiguration reset is active high.

Once the PLL lock indication has passed through a two-flop synchronizer and reads high, the primary channel and the reconfiguration logic are released together. The sequencer then waits a settling interval, 10 ms by default, before it releases the secondary channels. Channels that are neither the primary nor in the secondary mask stay in reset for good. If lock is lost at any point, or a restart is requested, the whole sequence starts over from the fully asserted state.

The settling count is worked out from the clock frequency and the interval in microseconds. A separate parameter can replace it with a short cycle count for simulation.

Top module: `chan_rst_seq`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after it, `csr_rst_n` is 4'b0000, `reconfig_rst` is 1 and `seq_done` is 0.
- R2: While the synchronized lock reads low, every reset output stays asserted.
- R3: Suppose `pll_lock` is first sampled high at clock edge k. Then after edge k+2 the `PRIMARY` bit of `csr_rst_n` goes to 1 and `reconfig_rst` goes to 0, both in the same cycle. Before that edge they are unchanged.
- R4: Every secondary bit is released exactly DELAY cycles after the primary release. DELAY is `SIM_CYCLES` when that is nonzero, and CLK_HZ/1,000,000 × SETTLE_US otherwise (1,000,000 cycles for 10 ms at 100 MHz).
- R5: Any bit of `csr_rst_n` that is neither `PRIMARY` nor set in `SEC_MASK` is always 0.
- R6: Suppose `pll_lock` is sampled low at edge k after lock was acquired. Then after edge k+2 all resets are asserted again, and the sequence waits for lock once more.
- R7: If `restart` is sampled high at an edge, all resets are asserted after that edge. While `restart` stays high, the sequence does not advance.
- R8: `seq_done` is 1 exactly when every enabled channel bit is 1 and `reconfig_rst` is 0.
- R9: An interrupted settling wait does not carry over. Every new primary release is followed by a full DELAY-cycle wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high system reset |
| pll_lock | input | 1 | Lock indication from the shared lane PLL (asynchronous) |
| restart | input | 1 | Request to restart the whole reset sequence |
| csr_rst_n | output | 4 | Per-channel control/status resets, active low |
| reconfig_rst | output | 1 | Reconfiguration reset, active high |
| seq_done | output | 1 | All enabled channels and reconfiguration released |

## Verification
A wrong state in the sequencer shows up at once as a wrong reset vector. There are only three legal vectors: all asserted, primary only, and all enabled channels released. An illegal mix appears on the very cycle the state goes wrong. A settling counter that is off by even one cycle moves the secondary release edge, so the bench measures the exact distance between the primary and secondary release edges. Errors in the synchronizer depth, or a recovery step missed after lock loss or restart, show up as a release or re-assertion one edge early or late. A cycle-by-cycle reference comparison under random lock loss, restart and reset catches these within a few cycles.

// File: rtl/chan_rst_pkg.sv
package chan_rst_pkg;

    localparam int unsigned NUM_CHAN = 4;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_PRIMARY = 2'd1,
        ST_ALL     = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [NUM_CHAN-1:0] chan_n;
        logic                reconf;
        logic                done;
    } rst_out_t;

    function automatic int unsigned settle_cycles(input int unsigned clk_hz,
                                                  input int unsigned settle_us,
                                                  input int unsigned sim_cycles);
        longint unsigned full;
        full = (longint'(clk_hz) / 64'd1_000_000) * longint'(settle_us);
        if (sim_cycles != 0)
            return sim_cycles;
        if (full == 0)
            return 1;
        return int'(full);
    endfunction

    function automatic logic [NUM_CHAN-1:0] primary_bit(input int unsigned idx);
        return NUM_CHAN'(1) << idx;
    endfunction

    function automatic logic [NUM_CHAN-1:0] enabled_bits(input int unsigned idx,
                                                         input logic [NUM_CHAN-1:0] sec);
        return primary_bit(idx) | sec;
    endfunction

endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int unsigned DELAY = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW   = $clog2(DELAY + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import chan_rst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lock_ok,
    input  logic       restart,
    input  logic       settle_expired,
    output seq_state_e state
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        if (restart) begin
            nxt = ST_HOLD;
        end else begin
            unique case (state)
                ST_HOLD:    if (lock_ok) nxt = ST_PRIMARY;
                ST_PRIMARY: begin
                    if (!lock_ok)            nxt = ST_HOLD;
                    else if (settle_expired) nxt = ST_ALL;
                end
                ST_ALL:     if (!lock_ok) nxt = ST_HOLD;
                default:    nxt = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_HOLD;
        else
            state <= nxt;
    end
endmodule

// File: rtl/chan_rst_seq.sv
module chan_rst_seq
    import chan_rst_pkg::*;
#(
    parameter int unsigned          CLK_HZ     = 100_000_000,
    parameter int unsigned          SETTLE_US  = 10_000,
    parameter int unsigned          SIM_CYCLES = 0,
    parameter int unsigned          PRIMARY    = 0,
    parameter logic [NUM_CHAN-1:0]  SEC_MASK   = 4'b1110
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pll_lock,
    input  logic                restart,
    output logic [NUM_CHAN-1:0] csr_rst_n,
    output logic                reconfig_rst,
    output logic                seq_done
);
    localparam int unsigned         DELAY   = settle_cycles(CLK_HZ, SETTLE_US, SIM_CYCLES);
    localparam logic [NUM_CHAN-1:0] PRI_BIT = primary_bit(PRIMARY);
    localparam logic [NUM_CHAN-1:0] EN_BITS = enabled_bits(PRIMARY, SEC_MASK);

    logic       lock_ok;
    logic       settle_expired;
    seq_state_e state;
    rst_out_t   outs;

    lock_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pll_lock),
        .sync_out (lock_ok)
    );

    settle_timer #(.DELAY(DELAY)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_PRIMARY),
        .expired (settle_expired)
    );

    seq_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .lock_ok        (lock_ok),
        .restart        (restart),
        .settle_expired (settle_expired),
        .state          (state)
    );

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        always_comb begin
            unique case (state)
                ST_PRIMARY: outs.chan_n[ch] = PRI_BIT[ch];
                ST_ALL:     outs.chan_n[ch] = EN_BITS[ch];
                default:    outs.chan_n[ch] = 1'b0;
            endcase
        end
    end

    assign outs.reconf = (state == ST_HOLD);
    assign outs.done   = (state == ST_ALL);

    assign csr_rst_n    = outs.chan_n;
    assign reconfig_rst = outs.reconf;
    assign seq_done     = outs.done;
endmodule

// File: rtl/chan_rst_seq_chk.sv
module chan_rst_seq_chk #(
    parameter int unsigned DELAY   = 1,
    parameter int unsigned PRIMARY = 0,
    parameter logic [3:0]  EN_BITS = 4'b0001
) (
    input logic       clk,
    input logic       rst,
    input logic       pll_lock,
    input logic       restart,
    input logic [3:0] csr_rst_n,
    input logic       reconfig_rst,
    input logic       seq_done
);
    logic        rst_d = 1'b0;
    logic [31:0] since_pri = '0;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst || reconfig_rst)
            since_pri <= '0;
        else if (since_pri != 32'hFFFF_FFFF)
            since_pri <= since_pri + 1;
    end

    // R1: held in reset during and right after the system reset
    always @(negedge clk) begin
        if (rst_d === 1'b1)
            a_r1_reset_hold: assert (csr_rst_n == 4'b0000 && reconfig_rst && !seq_done);
    end

    a_r3_primary_with_reconf: assert property (@(posedge clk) disable iff (rst)
        $rose(csr_rst_n[PRIMARY]) |-> ($fell(reconfig_rst) && $past(pll_lock, 2)));

    a_r4_settle_length: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_done) |-> (since_pri == DELAY));

    a_r5_unused_held: assert property (@(posedge clk) disable iff (rst)
        (csr_rst_n & ~EN_BITS) == 4'b0000);

    a_r7_restart_asserts: assert property (@(posedge clk) disable iff (rst)
        restart |=> (csr_rst_n == 4'b0000 && reconfig_rst));

    a_r8_done_meaning: assert property (@(posedge clk) disable iff (rst)
        seq_done == (csr_rst_n == EN_BITS && !reconfig_rst));
endmodule

bind chan_rst_seq chan_rst_seq_chk #(
    .DELAY   (DELAY),
    .PRIMARY (PRIMARY),
    .EN_BITS (EN_BITS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pll_lock     (pll_lock),
    .restart      (restart),
    .csr_rst_n    (csr_rst_n),
    .reconfig_rst (reconfig_rst),
    .seq_done     (seq_done)
);

// File: tb/test_chan_rst_seq.sv
module test_chan_rst_seq;
    localparam int unsigned DLY = 50;
    localparam int unsigned PRI = 2;
    localparam logic [3:0]  SEC = 4'b0011;
    localparam logic [3:0]  EN  = 4'b0111;

    localparam logic [5:0] E_HOLD = {4'b0000, 1'b1, 1'b0};
    localparam logic [5:0] E_PRI  = {4'b0100, 1'b0, 1'b0};
    localparam logic [5:0] E_ALL  = {EN,      1'b0, 1'b1};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pll_lock = 1'b0;
    logic       restart = 1'b0;
    logic [3:0] csr_rst_n;
    logic       reconfig_rst;
    logic       seq_done;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          model_on = 1'b0;

    always #4 clk = ~clk;

    chan_rst_seq #(
        .CLK_HZ     (125_000_000),
        .SETTLE_US  (10_000),
        .SIM_CYCLES (DLY),
        .PRIMARY    (PRI),
        .SEC_MASK   (SEC)
    ) i_chan_rst_seq (
        .clk          (clk),
        .rst          (rst),
        .pll_lock     (pll_lock),
        .restart      (restart),
        .csr_rst_n    (csr_rst_n),
        .reconfig_rst (reconfig_rst),
        .seq_done     (seq_done)
    );

    // Timeline reference derived from R1..R9: phase 0 hold, 1 primary, 2 all
    logic        m_l1 = 1'b0, m_l2 = 1'b0;
    int unsigned m_ph = 0;
    int unsigned m_wait = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_l1 <= 1'b0; m_l2 <= 1'b0; m_ph <= 0; m_wait <= 0;
        end else begin
            m_l1 <= pll_lock;
            m_l2 <= m_l1;
            if (restart) begin
                m_ph <= 0; m_wait <= 0;
            end else if (m_ph == 0) begin
                m_wait <= 0;
                if (m_l2) m_ph <= 1;
            end else if (!m_l2) begin
                m_ph <= 0; m_wait <= 0;
            end else if (m_ph == 1) begin
                if (m_wait + 1 == DLY) begin m_ph <= 2; m_wait <= 0; end
                else m_wait <= m_wait + 1;
            end
        end
    end

    function automatic logic [5:0] expect_of(input int unsigned ph);
        case (ph)
            1:       return E_PRI;
            2:       return E_ALL;
            default: return E_HOLD;
        endcase
    endfunction

    function automatic logic [5:0] observed();
        return {csr_rst_n, reconfig_rst, seq_done};
    endfunction

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got csr=%b reconf=%b done=%b, expected csr=%b reconf=%b done=%b",
                     req, act[5:2], act[1], act[0], exp[5:2], exp[1], exp[0]);
        end
    endtask

    task automatic step(input int unsigned n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(negedge clk) begin
        if (model_on) chk("MODEL", observed(), expect_of(m_ph));
    end

    initial begin
        repeat (200_000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL WATCHDOG: got timeout, expected completion");
        finish_run();
    end

    initial begin
        step(3);
        chk("R1", observed(), E_HOLD);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step(1);
            chk("R2", observed(), E_HOLD);
        end
        pll_lock = 1'b1;
        step(2);
        chk("R3 early", observed(), E_HOLD);
        step(1);
        chk("R3", observed(), E_PRI);
        step(DLY - 1);
        chk("R4 before", observed(), E_PRI);
        step(1);
        chk("R4 release", observed(), E_ALL);
        chk("R8", {5'b0, seq_done}, 6'd1);
        chk("R5 bit3", {5'b0, csr_rst_n[3]}, 6'd0);

        restart = 1'b1;
        step(1);
        restart = 1'b0;
        chk("R7", observed(), E_HOLD);
        step(1);
        chk("R7 resume", observed(), E_PRI);
        step(10);
        pll_lock = 1'b0;
        step(2);
        chk("R6 early", observed(), E_PRI);
        step(1);
        chk("R6", observed(), E_HOLD);
        pll_lock = 1'b1;
        step(3);
        chk("R9 rerelease", observed(), E_PRI);
        step(DLY - 1);
        chk("R9 full wait", observed(), E_PRI);
        step(1);
        chk("R9 end", observed(), E_ALL);

        restart = 1'b1;
        step(5);
        chk("R7 held", observed(), E_HOLD);
        restart = 1'b0;
        step(DLY + 1);
        chk("R4 again", observed(), E_ALL);
        pll_lock = 1'b0;
        step(3);
        chk("R6 from done", observed(), E_HOLD);
        pll_lock = 1'b1;
        step(3);
        rst = 1'b1;
        step(1);
        chk("R1 midrun", observed(), E_HOLD);
        rst = 1'b0;

        model_on = 1'b1;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 199) == 0) pll_lock = ~pll_lock;
            restart = ($urandom_range(0, 299) == 0);
            rst     = ($urandom_range(0, 2999) == 0);
            step(1);
        end
        restart = 1'b0;
        rst = 1'b0;
        step(2);
        model_on = 1'b0;
        finish_run();
    end
endmodule